// File: doc/BRIEF.md
# Indexed-Opcode SPI Command Sequencer

This block is an SPI master that runs single flash-style commands for software. Software does not hand over the opcode byte with each command. It loads a table of eight opcodes once, together with a 2-bit type for each table slot, and then starts a command by naming a slot. The slot's type decides two things: whether a 24-bit address follows the opcode, and whether the data phase reads from or writes to the shared 64-byte data buffer.

A command may ask for a prefix cycle. In that case the low byte of the prefix register goes out as a one-byte frame on its own. Chip select is then released for a short fixed gap, and the main command follows at once. Nothing else can be started in between, so a pair such as write-enable followed by a program command stays together.

Completion and collision errors are reported through status flags that software clears by writing one to them. A sticky lock bit freezes the opcode table, the type register and the prefix register.

Top module: `spi_menu_seq`

## Requirements
- R1: After reset, status reads 0, chip select is high, SCK is low and the clock-divider register reads 2.
- R2: Register 1 is the control register. Writing it with bit 1 set starts a command, and bits 6:4 pick a slot of the opcode table. Table slot i is byte i of registers 3 (slots 0–3) and 4 (slots 4–7), least significant byte first. The chosen opcode is the first byte of the frame. The link runs in SPI mode 0: SCK idles low, data is sampled on the rising edge, and each byte is sent MSB first.
- R3: Register 5 holds the type of slot i at bits [2i+1:2i]. Type 0 is a read without address, 1 a write without address, 2 a read with address and 3 a write with address. When the type has an address, the low 24 bits of register 2 follow the opcode, most significant byte first.
- R4: Control bit 14 enables the data phase, and control bits 13:8 hold the byte count minus one (1 to 64 bytes). With bit 14 clear the frame holds only the opcode and any address.
- R5: On a read data phase the master sends 0x00 bytes. Received data byte k is stored at bits 8*(k%4)+7:8*(k%4) of data word k/4, which is register 16+k/4. Buffer bytes beyond the count keep their values.
- R6: On a write data phase, data byte k is taken from the same buffer position.
- R7: When control bit 2 is set, the low byte of register 6 is sent as its own one-byte frame first. Chip select then stays high for at least 2 clock cycles before the main frame starts.
- R8: Status (register 0) bit 0 is high while a command runs. Bit 2 is set when a command finishes. Writing 1 to bit 2 clears it, and writing 1 to bit 3 clears bit 3. Chip select is high whenever no command runs.
- R9: A start request while a command runs sets status bit 3. The running command goes on unchanged.
- R10: Writing 1 to status bit 15 sets the lock, which holds until reset. While locked, writes to registers 3 to 6 are ignored, and the old opcode table stays in use.
- R11: Register 7 sets the SCK half-period in clock cycles. A value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register select for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Master data in |

## Verification
The bench drives random slots, types, counts, addresses and dividers. It also runs directed cases for the edges where a sequencer tends to slip. The first is a 64-byte read: a count field read without its minus-one offset would drop or add a byte there. The second is an addressed command with the data phase disabled, which a design that ignores bit 14 would pad with data bytes. The third is the prefix frame followed by a closely measured chip-select gap: a design that merges the two frames would show one long frame. The remaining cases are a start request issued mid-command, which a careless design would use to restart or corrupt the running frame, and writes to the table after locking, which would otherwise change the opcode sent on the next command. On reads, the whole buffer is compared, so bytes stored at a wrong lane or beyond the count are caught.

// File: rtl/spi_menu_seq.sv
`timescale 1ns/1ps
module spi_menu_seq #(
  parameter int DATA_BYTES = 64,
  parameter int DIV_W      = 8,
  parameter int GAP_CYC    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int WORDS = DATA_BYTES / 4;
  localparam int WI    = $clog2(WORDS);
  localparam int BW    = $clog2(DATA_BYTES + 5);
  localparam int GW    = $clog2(GAP_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_GAP, S_MAIN} st_t;

  logic [63:0]      menu_q;
  logic [15:0]      type_q, pref_q, ctrl_q;
  logic [31:0]      addr_q;
  logic [DIV_W-1:0] div_q, hc, hp;
  logic             done_q, err_q, lock_q;
  logic [31:0]      dbuf [WORDS];

  st_t              st;
  logic             sck_q, cs_q;
  logic [2:0]       bitc;
  logic [BW-1:0]    bi, nb, hdr, di, c_n;
  logic [GW-1:0]    gapc;
  logic [7:0]       rx, cur, c_op, c_pre;
  logic [23:0]      c_addr;
  logic             c_adr, c_wr, c_den, busy, cap_rd;
  logic [2:0]       sidx;
  logic [1:0]       styp;

  assign busy     = st != S_IDLE;
  assign hp       = (div_q == '0) ? DIV_W'(1) : div_q;
  assign hdr      = c_adr ? BW'(4) : BW'(1);
  assign nb       = (st == S_PRE) ? BW'(1) : hdr + (c_den ? c_n : BW'(0));
  assign di       = bi - hdr;
  assign cap_rd   = st == S_MAIN && c_den && !c_wr && bi >= hdr;
  assign sidx     = reg_wdata[6:4];
  assign styp     = type_q[{sidx, 1'b0} +: 2];
  assign spi_sck  = sck_q;
  assign spi_cs_n = cs_q;
  assign spi_mosi = (st == S_PRE || st == S_MAIN) ? cur[3'd7 - bitc] : 1'b0;

  always_comb begin
    if (st == S_PRE)            cur = c_pre;
    else if (bi == '0)          cur = c_op;
    else if (c_adr && bi < BW'(4))
      case (bi[1:0])
        2'd1:    cur = c_addr[23:16];
        2'd2:    cur = c_addr[15:8];
        default: cur = c_addr[7:0];
      endcase
    else if (c_wr)              cur = dbuf[di[WI+1:2]][{di[1:0], 3'b000} +: 8];
    else                        cur = 8'h00;
  end

  always_comb begin
    if (reg_addr[4]) reg_rdata = dbuf[reg_addr[WI-1:0]];
    else
      case (reg_addr[3:0])
        4'd0:    reg_rdata = {16'h0, lock_q, 11'h0, err_q, done_q, 1'b0, busy};
        4'd1:    reg_rdata = {16'h0, ctrl_q};
        4'd2:    reg_rdata = addr_q;
        4'd3:    reg_rdata = menu_q[31:0];
        4'd4:    reg_rdata = menu_q[63:32];
        4'd5:    reg_rdata = {16'h0, type_q};
        4'd6:    reg_rdata = {16'h0, pref_q};
        4'd7:    reg_rdata = {{(32-DIV_W){1'b0}}, div_q};
        default: reg_rdata = '0;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      menu_q <= '0; type_q <= '0; pref_q <= '0; ctrl_q <= '0; addr_q <= '0;
      div_q <= DIV_W'(2); done_q <= 1'b0; err_q <= 1'b0; lock_q <= 1'b0;
      for (int i = 0; i < WORDS; i++) dbuf[i] <= '0;
      st <= S_IDLE; sck_q <= 1'b0; cs_q <= 1'b1; bitc <= '0; bi <= '0;
      hc <= '0; gapc <= '0; rx <= '0; c_op <= '0; c_pre <= '0; c_addr <= '0;
      c_adr <= 1'b0; c_wr <= 1'b0; c_den <= 1'b0; c_n <= '0;
    end else begin
      if (reg_wr) begin
        if (reg_addr[4]) dbuf[reg_addr[WI-1:0]] <= reg_wdata;
        else
          case (reg_addr[3:0])
            4'd0: begin
              if (reg_wdata[2])  done_q <= 1'b0;
              if (reg_wdata[3])  err_q  <= 1'b0;
              if (reg_wdata[15]) lock_q <= 1'b1;
            end
            4'd1:
              if (busy) begin
                if (reg_wdata[1]) err_q <= 1'b1;
              end else begin
                ctrl_q <= reg_wdata[15:0] & 16'hfffd;
                if (reg_wdata[1]) begin
                  c_op   <= menu_q[{sidx, 3'b000} +: 8];
                  c_adr  <= styp[1];
                  c_wr   <= styp[0];
                  c_den  <= reg_wdata[14];
                  c_n    <= BW'(reg_wdata[13:8]) + BW'(1);
                  c_addr <= addr_q[23:0];
                  c_pre  <= pref_q[7:0];
                  st     <= reg_wdata[2] ? S_PRE : S_MAIN;
                  cs_q   <= 1'b0;
                  bi <= '0; bitc <= '0; hc <= '0; sck_q <= 1'b0;
                end
              end
            4'd2: addr_q <= reg_wdata;
            4'd3: if (!lock_q) menu_q[31:0]  <= reg_wdata;
            4'd4: if (!lock_q) menu_q[63:32] <= reg_wdata;
            4'd5: if (!lock_q) type_q <= reg_wdata[15:0];
            4'd6: if (!lock_q) pref_q <= reg_wdata[15:0];
            4'd7: div_q <= reg_wdata[DIV_W-1:0];
            default: ;
          endcase
      end

      case (st)
        S_PRE, S_MAIN:
          if (hc == hp - DIV_W'(1)) begin
            hc <= '0;
            if (!sck_q) begin
              sck_q <= 1'b1;
              rx    <= {rx[6:0], spi_miso};
            end else begin
              sck_q <= 1'b0;
              bitc  <= bitc + 3'd1;
              if (bitc == 3'd7) begin
                if (cap_rd) dbuf[di[WI+1:2]][{di[1:0], 3'b000} +: 8] <= rx;
                if (bi == nb - BW'(1)) begin
                  cs_q <= 1'b1;
                  bi   <= '0;
                  if (st == S_PRE) begin
                    st <= S_GAP; gapc <= '0;
                  end else begin
                    st <= S_IDLE; done_q <= 1'b1;
                  end
                end else bi <= bi + BW'(1);
              end
            end
          end else hc <= hc + DIV_W'(1);
        S_GAP:
          if (gapc == GW'(GAP_CYC - 1)) begin
            st <= S_MAIN; cs_q <= 1'b0;
          end else gapc <= gapc + GW'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_menu_seq_chk.sv
`timescale 1ns/1ps
module spi_menu_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        sck,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        lock,
  input logic        reg_wr,
  input logic [4:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [63:0] menu,
  input logic [15:0] typ,
  input logic [15:0] pref
);
  a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  a_r8_cs_high_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
  a_r7_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);
  a_r8_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r9_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 5'd1 && reg_wdata[1] && busy) |=> err);
  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
  a_r10_tables_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(menu) && $stable(typ) && $stable(pref)));
endmodule

bind spi_menu_seq spi_menu_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .busy(busy),
  .done(done_q), .err(err_q), .lock(lock_q), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .menu(menu_q), .typ(type_q),
  .pref(pref_q)
);

// File: tb/spi_menu_seq_tb_top.sv
`timescale 1ns/1ps
module spi_menu_seq_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sck, cs_n, mosi, miso;

  always #2 clk = ~clk;

  spi_menu_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(sck),
    .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
  );

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  logic [7:0] resp [80];
  logic [7:0] cap [160];
  int fr_len [8];
  int rbits = 0, cap_n = 0, fr_n = 0, gap_cyc = 0, hi_cyc = 0;
  logic [7:0] sh = '0;
  realtime t_rise = 0, t_hi = 0;

  logic [7:0]  m_menu [8];
  logic [15:0] m_type, m_pref;
  logic [7:0]  m_buf [64];

  always @(negedge cs_n) begin
    if (fr_n > 0) gap_cyc = int'(($realtime - t_rise) / 4.0);
    rbits = 0;
  end
  always @(posedge cs_n) begin
    t_rise = $realtime;
    if (fr_n < 8) fr_len[fr_n] = rbits / 8;
    fr_n++;
  end
  always @(posedge sck) if (!cs_n) begin
    sh = {sh[6:0], mosi};
    rbits++;
    if (rbits % 8 == 0 && cap_n < 160) begin cap[cap_n] = sh; cap_n++; end
    t_hi = $realtime;
  end
  always @(negedge sck) hi_cyc = int'(($realtime - t_hi) / 4.0);
  always_comb miso = cs_n ? 1'b0 : resp[(rbits / 8) % 80][7 - (rbits % 8)];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    bit idle = 1'b0;
    for (int i = 0; i < 20000 && !idle; i++) begin
      rd(5'd0, s);
      idle = !s[0];
    end
    chk(idle, "R8 busy clears", {31'b0, idle}, 32'd1);
  endtask

  task automatic load_tables();
    wr(5'd3, {m_menu[3], m_menu[2], m_menu[1], m_menu[0]});
    wr(5'd4, {m_menu[7], m_menu[6], m_menu[5], m_menu[4]});
    wr(5'd5, {16'h0, m_type});
    wr(5'd6, {16'h0, m_pref});
  endtask

  task automatic load_buf();
    for (int w = 0; w < 16; w++)
      wr(5'(16 + w), {m_buf[4*w+3], m_buf[4*w+2], m_buf[4*w+1], m_buf[4*w]});
  endtask

  task automatic check_buf(input string tag);
    logic [31:0] d;
    for (int w = 0; w < 16; w++) begin
      rd(5'(16 + w), d);
      chk(d == {m_buf[4*w+3], m_buf[4*w+2], m_buf[4*w+1], m_buf[4*w]}, tag, d,
          {m_buf[4*w+3], m_buf[4*w+2], m_buf[4*w+1], m_buf[4*w]});
    end
  endtask

  task automatic run_cmd(input int idx, input bit atom, input bit den, input int n,
                         input logic [31:0] addr, input bit collide);
    logic [1:0]  t;
    int          hdr, base, mlen;
    logic [7:0]  e;
    logic [31:0] s;
    t = m_type[2*idx +: 2];
    hdr = t[1] ? 4 : 1;
    mlen = hdr + (den ? n : 0);
    for (int j = 0; j < 80; j++) resp[j] = 8'($urandom);
    wr(5'd2, addr);
    cap_n = 0; fr_n = 0; gap_cyc = 0;
    wr(5'd1, (32'(den) << 14) | (32'(n - 1) << 8) | (32'(idx) << 4) | (32'(atom) << 2) | 32'h2);
    if (collide) begin
      wr(5'd1, (32'((idx + 1) % 8) << 4) | 32'h2);
      rd(5'd0, s);
      chk(s[3] == 1'b1 && s[0] == 1'b1, "R9 error on start while busy", s, 32'h9);
    end
    wait_idle();
    chk(fr_n == (atom ? 2 : 1), "R7 frame count", 32'(fr_n), atom ? 32'd2 : 32'd1);
    base = 0;
    if (atom) begin
      chk(fr_len[0] == 1, "R7 prefix frame length", 32'(fr_len[0]), 32'd1);
      chk(cap[0] == m_pref[7:0], "R7 prefix byte", {24'h0, cap[0]}, {24'h0, m_pref[7:0]});
      chk(gap_cyc >= 2, "R7 chip-select gap", 32'(gap_cyc), 32'd2);
      base = 1;
    end
    chk(fr_len[base] == mlen, "R4 main frame length", 32'(fr_len[base]), 32'(mlen));
    chk(cap[base] == m_menu[idx], "R2 opcode from slot", {24'h0, cap[base]}, {24'h0, m_menu[idx]});
    if (t[1])
      for (int j = 1; j < 4; j++) begin
        e = addr[8*(3-j) +: 8];
        chk(cap[base+j] == e, "R3 address byte", {24'h0, cap[base+j]}, {24'h0, e});
      end
    if (den)
      for (int k = 0; k < n; k++) begin
        e = t[0] ? m_buf[k] : 8'h00;
        chk(cap[base+hdr+k] == e, t[0] ? "R6 write data byte" : "R5 read sends zero",
            {24'h0, cap[base+hdr+k]}, {24'h0, e});
        if (!t[0]) m_buf[k] = resp[hdr+k];
      end
    rd(5'd0, s);
    chk(s[2] == 1'b1 && s[0] == 1'b0, "R8 done set", s, 32'h4);
    wr(5'd0, 32'h4);
    rd(5'd0, s);
    chk(s[2] == 1'b0, "R8 done cleared", s, 32'h0);
    if (den && !t[0]) check_buf("R5 buffer after read");
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, d;
    void'($urandom(32'h1c3d));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(5'd0, s); chk(s == 32'h0, "R1 status at reset", s, 32'h0);
    chk(cs_n == 1'b1 && sck == 1'b0, "R1 bus idle at reset", {30'b0, cs_n, sck}, 32'h2);
    rd(5'd7, d); chk(d == 32'd2, "R1 divider at reset", d, 32'd2);

    for (int i = 0; i < 8; i++) m_menu[i] = 8'($urandom);
    m_type = {8'($urandom), 2'd3, 2'd2, 2'd1, 2'd0};
    m_pref = 16'($urandom);
    for (int i = 0; i < 64; i++) m_buf[i] = 8'($urandom);
    load_tables(); load_buf();
    rd(5'd5, d); chk(d[15:0] == m_type, "R3 type readback", d, {16'h0, m_type});

    run_cmd(0, 0, 1, 3, 32'h00a1b2c3, 0);
    run_cmd(1, 0, 1, 5, 32'h0, 0);
    run_cmd(2, 1, 1, 7, 32'hff123456, 0);
    run_cmd(3, 1, 1, 9, 32'h00654321, 0);
    run_cmd(2, 0, 1, 64, 32'h00000100, 0);
    run_cmd(3, 0, 0, 4, 32'h00abcdef, 0);
    run_cmd(1, 1, 0, 1, 32'h0, 0);

    wr(5'd7, 32'd0); run_cmd(0, 0, 1, 2, 32'h0, 0);
    chk(hi_cyc == 1, "R11 half period for 0", 32'(hi_cyc), 32'd1);
    wr(5'd7, 32'd3); run_cmd(2, 0, 1, 2, 32'h10, 0);
    chk(hi_cyc == 3, "R11 half period 3", 32'(hi_cyc), 32'd3);
    wr(5'd7, 32'd5); run_cmd(4, 1, 0, 1, 32'h20, 0);
    chk(hi_cyc == 5, "R11 half period 5", 32'(hi_cyc), 32'd5);

    for (int r = 0; r < 25; r++) begin
      wr(5'd7, 32'($urandom_range(1, 3)));
      run_cmd($urandom_range(0, 7), 1'($urandom), 1'($urandom),
              $urandom_range(1, 16), $urandom, 0);
    end

    wr(5'd7, 32'd2);
    run_cmd(3, 0, 1, 8, 32'h00777777, 1);
    rd(5'd0, s); chk(s[3] == 1'b1 && s[2] == 1'b0, "R8 error kept after done clear", s, 32'h8);
    wr(5'd0, 32'h8);
    rd(5'd0, s); chk(s[3] == 1'b0, "R8 error cleared by write one", s, 32'h0);

    wr(5'd0, 32'h8000);
    rd(5'd0, s); chk(s[15] == 1'b1, "R10 lock set", s, 32'h8000);
    wr(5'd3, 32'h11111111); wr(5'd4, 32'h22222222);
    wr(5'd5, 32'h5555); wr(5'd6, 32'h00ee);
    rd(5'd3, d); chk(d == {m_menu[3], m_menu[2], m_menu[1], m_menu[0]}, "R10 table held",
                     d, {m_menu[3], m_menu[2], m_menu[1], m_menu[0]});
    rd(5'd5, d); chk(d[15:0] == m_type, "R10 type held", d, {16'h0, m_type});
    rd(5'd6, d); chk(d[15:0] == m_pref, "R10 prefix held", d, {16'h0, m_pref});
    run_cmd(5, 1, 0, 1, 32'h0, 0);
    wr(5'd0, 32'h0);
    rd(5'd0, s); chk(s[15] == 1'b1, "R10 lock sticky", s, 32'h8000);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule